// File: doc/BRIEF.md
# Page-Boundary Burst Splitter

This block takes a transfer request, given as a start byte address and a count of 32-bit words, and hands it to a downstream bus master as a series of burst commands. Each burst is kept inside one 1 KB page of 256 words. The downstream bridge wraps addresses inside a page, so a burst that ran past the page edge would write back over the start of the same page. For each sub-burst, the length is cut to the smaller of two values: the words still owed, and the distance to the next page edge. After each sub-burst the next one starts at the page base.

Once the downstream side accepts a command, the block raises a word strobe on each clock cycle of that burst, one cycle per word. When the last word of the last burst goes out, it raises a one-cycle done pulse. There are two special cases. A request with zero words finishes at once. A request whose start address is not word aligned raises an error pulse and produces no bus traffic.

Top module: `page_burst_splitter`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1 and `cmd_valid`, `word_stb`, `done` and `err` are all 0.
- R2: Each command length equals min(words remaining, 256 − addr[9:2]), where addr[9:2] is the word offset inside the 1 KB page. The word offset plus the length never exceeds 256.
- R3: After a burst, the next command address is the previous address plus 4 × length, and the words remaining drop by that length. Commands keep coming until the request is used up.
- R4: A request for exactly one word produces a single command with length 1 and a single word strobe.
- R5: After a command handshake (`cmd_valid` and `cmd_ready` both high), `word_stb` is high on exactly `cmd_len` consecutive cycles, starting on the next cycle.
- R6: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr` and `cmd_len` hold their values into the next cycle.
- R7: For a non-empty aligned request, `done` is a one-cycle pulse. It falls on the same cycle as the final word strobe of the final burst, and at no other time.
- R8: A request with zero words and an aligned address raises `done` in the cycle after it is accepted, and issues no command.
- R9: A request with addr[1:0] ≠ 0 raises `err` for one cycle, in the cycle after it is accepted. It issues no command and no `done`.
- R10: `req_ready` is high only while no request is in progress, so a new request is taken only when the block is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | ADDR_W | Start byte address |
| req_words | input | LEN_W | Number of words to move |
| cmd_valid | output | 1 | Burst command offered |
| cmd_ready | input | 1 | Downstream accepts command |
| cmd_addr | output | ADDR_W | Burst start byte address |
| cmd_len | output | BLEN_W | Burst length in words (1..256) |
| word_stb | output | 1 | One pulse per word moved |
| done | output | 1 | Request complete |
| err | output | 1 | Misaligned request rejected |

## Verification
The final word strobe of the last burst and the done pulse must land on the same cycle. Requests are shaped so that the last burst ends on a page edge, ends mid-page, or is a single word, and all of this runs while `cmd_ready` is stalled in a pseudo-random pattern. The scoreboard judges the coincidence at each strobe. If the burst counter reaches zero on the last burst of a request, `done` must be high on that strobe. A `done` at any other time counts as a failure, except in the cycle after a zero-length request is accepted.

// File: rtl/pbs_pkg.sv
// Package: shared state type for the page-boundary burst splitter.
// Assumes: nothing beyond a single clock domain.
package pbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_XFER  = 2'd2
    } pbs_state_t;

endpackage

// File: rtl/pbs_len_calc.sv
// Module: pbs_len_calc
// Works out the length of the next sub-burst as the smaller of the words
// remaining and the room left before the page edge.
// Assumes: page_ofs is the word offset inside the page; remain is non-zero
// whenever the result is used.
module pbs_len_calc #(
    parameter int OFS_W = 8,
    parameter int LEN_W = 16,
    localparam int BLEN_W = OFS_W + 1
) (
    input  logic [OFS_W-1:0]  page_ofs,
    input  logic [LEN_W-1:0]  remain,
    output logic [BLEN_W-1:0] burst_len
);
    localparam int PAGE_WORDS = 1 << OFS_W;

    logic [BLEN_W-1:0] room;

    // Words left before the page edge (1..PAGE_WORDS)
    always_comb begin
        room = BLEN_W'(PAGE_WORDS) - {1'b0, page_ofs};
    end

    generate
        if (LEN_W > BLEN_W) begin : g_wide
            // Clip a wide remaining count to the page room
            always_comb begin
                if (remain < LEN_W'(room)) burst_len = BLEN_W'(remain);
                else                       burst_len = room;
            end
        end else begin : g_narrow
            // Remaining count no wider than the room value
            always_comb begin
                if (BLEN_W'(remain) < room) burst_len = BLEN_W'(remain);
                else                        burst_len = room;
            end
        end
    endgenerate

endmodule

// File: rtl/pbs_beat_ctr.sv
// Module: pbs_beat_ctr
// Counts down the words of one burst, one per clock, after a load.
// Assumes: load only while idle, with a non-zero length.
module pbs_beat_ctr #(
    parameter int BLEN_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BLEN_W-1:0] load_len,
    output logic              busy,
    output logic              last
);
    logic [BLEN_W-1:0] cnt;

    // Load the burst length, then step down once per word
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_len;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    // Decode the busy and final-word flags
    always_comb begin
        busy = (cnt != '0);
        last = (cnt == BLEN_W'(1));
    end

    // R5: a load never lands on a running burst
    assert_load_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

    // R5: a running count steps down by one per cycle
    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/page_burst_splitter.sv
// Module: page_burst_splitter
// Splits a word-count transfer into bursts that never cross a page edge,
// strobes once per word and pulses done at the final word.
// Assumes: one word per clock once a command is accepted; requests with a
// misaligned byte address are rejected.
module page_burst_splitter
    import pbs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 16,
    parameter int WORD_BYTES = 4,
    parameter int PAGE_BYTES = 1024,
    localparam int WORD_LSB   = $clog2(WORD_BYTES),
    localparam int PAGE_LSB   = $clog2(PAGE_BYTES),
    localparam int OFS_W      = PAGE_LSB - WORD_LSB,
    localparam int PAGE_WORDS = 1 << OFS_W,
    localparam int BLEN_W     = OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_words,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BLEN_W-1:0] cmd_len,
    output logic              word_stb,
    output logic              done,
    output logic              err
);
    pbs_state_t        state;
    logic [ADDR_W-1:0] cur_addr;
    logic [LEN_W-1:0]  remain;
    logic [BLEN_W-1:0] blen;
    logic [BLEN_W-1:0] calc_len;
    logic              err_q;
    logic              zdone_q;
    logic              ctr_busy;
    logic              ctr_last;
    logic              cmd_fire;
    logic              req_fire;
    logic              misaligned;
    logic              final_burst;

    pbs_len_calc #(.OFS_W(OFS_W), .LEN_W(LEN_W)) u_len (
        .page_ofs  (cur_addr[PAGE_LSB-1:WORD_LSB]),
        .remain    (remain),
        .burst_len (calc_len)
    );

    pbs_beat_ctr #(.BLEN_W(BLEN_W)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cmd_fire),
        .load_len (calc_len),
        .busy     (ctr_busy),
        .last     (ctr_last)
    );

    // Handshake and decode terms
    always_comb begin
        req_ready   = (state == ST_IDLE);
        req_fire    = req_valid && req_ready;
        misaligned  = (req_addr[WORD_LSB-1:0] != '0);
        cmd_valid   = (state == ST_ISSUE);
        cmd_fire    = cmd_valid && cmd_ready;
        cmd_addr    = cur_addr;
        cmd_len     = calc_len;
        final_burst = (remain == LEN_W'(blen));
        word_stb    = ctr_busy;
        done        = zdone_q || (state == ST_XFER && ctr_last && final_burst);
        err         = err_q;
    end

    // Sequencer: accept, issue each sub-burst, move words, step to the next page
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            remain   <= '0;
            blen     <= '0;
            err_q    <= 1'b0;
            zdone_q  <= 1'b0;
        end else begin
            err_q   <= 1'b0;
            zdone_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_fire) begin
                        cur_addr <= req_addr;
                        remain   <= req_words;
                        if (misaligned)             err_q   <= 1'b1;
                        else if (req_words == '0)   zdone_q <= 1'b1;
                        else                        state   <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (cmd_fire) begin
                        blen  <= calc_len;
                        state <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (ctr_last) begin
                        cur_addr <= cur_addr + (ADDR_W'(blen) << WORD_LSB);
                        remain   <= remain - LEN_W'(blen);
                        state    <= final_burst ? ST_IDLE : ST_ISSUE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a command never reaches past the page edge
    assert_no_page_cross_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (({1'b0, cur_addr[PAGE_LSB-1:WORD_LSB]} + (BLEN_W+1)'(cmd_len))
                       <= (BLEN_W+1)'(PAGE_WORDS)));

    // R2: a command never asks for zero words
    assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len != '0));

    // R6: a stalled command holds steady
    assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_len)));

    // R5: words move only in the transfer phase, never beside a command
    assert_stb_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb == (state == ST_XFER));

    // R5: the first word follows the command handshake
    assert_stb_after_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> word_stb);

    // R10: no request is taken while work is in flight
    assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cmd_valid && !word_stb));

    // R7: done is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: an error never comes with a completion
    assert_err_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && done));

endmodule

// File: tb/page_burst_splitter_test.sv
module page_burst_splitter_test;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 16;
    localparam int BLEN_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_words = '0;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [ADDR_W-1:0] cmd_addr;
    logic [BLEN_W-1:0] cmd_len;
    logic              word_stb;
    logic              done;
    logic              err;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [ADDR_W-1:0] addr;
        int                len;
        bit                last;
    } exp_cmd_t;

    exp_cmd_t exp_q[$];
    int  pend = 0;
    bit  cur_last = 0;
    bit  monitor_on = 0;
    bit  req_done_seen = 0;
    bit  stall_en = 0;
    logic [7:0] lfsr = 8'hA5;
    bit  prev_stall = 0;
    logic [ADDR_W-1:0] prev_addr;
    logic [BLEN_W-1:0] prev_len;

    page_burst_splitter uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_words(req_words),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .word_stb(word_stb), .done(done), .err(err)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive cmd_ready from a stall pattern, away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            cmd_ready = stall_en ? lfsr[0] : 1'b1;
        end
    end

    // Scoreboard monitor: commands, strobes, done coincidence, stall hold
    initial begin
        forever begin
            @(negedge clk);
            if (monitor_on) begin
                if (prev_stall) begin
                    check(cmd_valid && cmd_addr == prev_addr && cmd_len == prev_len,
                          "R6", "stalled command held", cmd_addr, prev_addr);
                end
                if (word_stb) begin
                    bit fin;
                    check(pend > 0, "R5", "strobe inside burst", pend, 1);
                    if (pend > 0) pend--;
                    fin = (pend == 0) && cur_last;
                    check(done == fin, "R7", "done on final strobe", done, fin);
                    if (fin && done) req_done_seen = 1;
                end else begin
                    check(pend == 0, "R5", "contiguous strobes", 0, 1);
                    if (done) check(0, "R7", "done without final strobe", 1, 0);
                end
                if ((pend > 0 || cmd_valid) && req_ready)
                    check(0, "R10", "ready while busy", 1, 0);
                if (cmd_valid && cmd_ready) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R3", "unexpected command", cmd_addr, 0);
                    end else begin
                        exp_cmd_t e;
                        e = exp_q.pop_front();
                        check(cmd_addr == e.addr, "R3", "command address", cmd_addr, e.addr);
                        check(int'(cmd_len) == e.len, "R2", "command length", cmd_len, e.len);
                        pend = e.len;
                        cur_last = e.last;
                    end
                end
                prev_stall = cmd_valid && !cmd_ready;
                prev_addr = cmd_addr;
                prev_len = cmd_len;
            end
        end
    end

    // Driver: compute expected sub-bursts, offer the request, await completion
    task automatic send_req(input logic [ADDR_W-1:0] a, input int words);
        logic [ADDR_W-1:0] ad;
        int left;
        ad = a;
        left = words;
        while (left > 0) begin
            exp_cmd_t e;
            int room;
            room = 256 - int'(ad[9:2]);
            e.addr = ad;
            e.len = (left < room) ? left : room;
            left -= e.len;
            e.last = (left == 0);
            exp_q.push_back(e);
            ad = ad + ADDR_W'(4 * e.len);
        end
        req_done_seen = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr = a;
        req_words = LEN_W'(words);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_done_seen) @(negedge clk);
        check(exp_q.size() == 0, "R3", "all sub-bursts issued", exp_q.size(), 0);
    endtask

    // Special requests (zero length, misaligned) judged one cycle after acceptance
    task automatic send_special(input logic [ADDR_W-1:0] a, input int words,
                                input bit exp_err, input string req);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        monitor_on = 0;
        req_valid = 1'b1;
        req_addr = a;
        req_words = LEN_W'(words);
        @(negedge clk);
        req_valid = 1'b0;
        check(err == exp_err, req, "err pulse", err, exp_err);
        check(done == !exp_err, req, "done pulse", done, !exp_err);
        check(!cmd_valid, req, "no command issued", cmd_valid, 0);
        @(negedge clk);
        check(!err && !done, req, "pulse lasts one cycle", err | done, 0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!cmd_valid && !word_stb && req_ready, req, "stays idle", cmd_valid, 0);
        end
        monitor_on = 1;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(0, "WD", "watchdog expired", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready && !cmd_valid && !word_stb && !done && !err,
              "R1", "reset outputs", {req_ready, cmd_valid, word_stb, done, err}, 5'b10000);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !cmd_valid && !done && !err, "R1", "idle after reset", req_ready, 1);
        monitor_on = 1;

        // R4: single word, mid page and at the last word of a page
        send_req(32'h0000_0100, 1);
        send_req(32'h0000_03FC, 1);
        // R2: short burst inside one page
        send_req(32'h0000_0040, 17);
        // R2 R3: split at the edge, 2 then 8 words
        send_req(32'h0000_03F8, 10);
        // R3: whole page from its base
        send_req(32'h0000_1000, 256);
        // R3: three pieces 255, 256, 189
        send_req(32'h0000_2004, 700);
        // R8: zero length
        send_special(32'h0000_0800, 0, 1'b0, "R8");
        // R9: misaligned start
        send_special(32'h0000_0102, 5, 1'b1, "R9");
        // R6 R7: stalled downstream
        stall_en = 1;
        send_req(32'h0000_33F0, 300);
        send_req(32'h0000_0008, 1);
        send_req(32'h0000_07F0, 4);
        send_req(32'h0000_4400, 513);
        stall_en = 0;
        send_req(32'h0000_0020, 3);

        repeat (5) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule